// File: doc/BRIEF.md
# Audio Frame Length Checker

This block guards the start of an audio path. When the enable request is raised, it measures how many bit-clock rising edges fall inside one full word-clock period, starting at the first word-clock rising edge it sees after the request. It then checks the configured sample length against that count. A length fits when it is no more than half the count, because each frame carries two channel slots.

Both the bit clock and the word clock are asynchronous to the system clock. Each passes through a synchronizer and then a rising-edge detector. A saturating counter accumulates bit-clock edges during the measured frame. A small state machine makes the decision. When the length fits, the run grant is asserted at the closing word-clock edge and stays up while the request is held. When it does not fit, the block latches an error, withholds the run grant, and raises an interrupt unless the mask is set.

The state machine has five states:
- `ST_IDLE` moves to `ST_ALIGN` on the enable request.
- `ST_ALIGN` moves to `ST_MEASURE` on a word-clock rise.
- `ST_MEASURE` moves to `ST_RUN` when the length fits, or to `ST_FAULT` when it does not, on the next word-clock rise.
- `ST_RUN` returns to `ST_IDLE` when the request is dropped.
- `ST_FAULT` returns to `ST_IDLE` on an error clear or when the request is dropped.

Dropping the request sends every state back to `ST_IDLE`.

Top module: `frame_len_guard`

## Requirements
- R1: After reset, run_grant, len_err and irq_out are all 0.
- R2: Both clock inputs are synchronized to clk. The count covers the bit-clock rising edges strictly between the first word-clock rise seen after enable_req goes high and the next word-clock rise.
- R3: When 2*data_len is at most the measured count, run_grant rises after the closing word-clock edge and len_err stays 0. For example, 20 bits passes with 40 bit clocks per frame.
- R4: When 2*data_len exceeds the measured count, len_err is set and run_grant is never asserted. For example, 21 bits fails with 40 bit clocks per frame.
- R5: irq_out equals len_err AND NOT irq_mask. With irq_mask = 1, irq_out stays 0 while len_err is 1, and a mask change takes effect within one cycle.
- R6: len_err stays set over any number of later frames until err_clear or the loss of enable_req. An err_clear with enable_req still high clears len_err on the next cycle and starts a new measurement.
- R7: One cycle after enable_req is low, run_grant, len_err and irq_out are all 0.
- R8: run_grant stays 0 from the raising of enable_req until the measured frame has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Bit clock, asynchronous to clk |
| wclk_in | input | 1 | Word clock, asynchronous to clk |
| data_len | input | LEN_W | Configured sample length in bits |
| enable_req | input | 1 | Request to start the audio path |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| err_clear | input | 1 | Host clear of a latched error |
| run_grant | output | 1 | Audio path may run |
| len_err | output | 1 | Latched length/bit-clock error |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench uses LEN_W = 6, CNT_W = 8 and SYNC_STAGES = 2. With these values, every even frame size from 4 to 40 bit clocks, plus an odd size, can be swept against lengths just below, at and just above half the frame. This puts the pass/fail boundary, including the 40-clock/20-bit case, in every frame size tried. The small widths also leave room to exercise the mask, the sticky error, the clear-and-remeasure path and the withdrawal of the request on each failing case.

// File: rtl/flg_pkg.sv
package flg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_MEASURE,
        ST_RUN,
        ST_FAULT
    } flg_state_e;
endpackage

// File: rtl/flg_edge_sync.sv
module flg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], din};
        end
    end

    // Rising edge seen on the synchronized signal
    assign rise_o = chain_q[DEPTH-2] & ~chain_q[DEPTH-1];
endmodule

// File: rtl/flg_bit_counter.sv
module flg_bit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/flg_ctrl.sv
module flg_ctrl
    import flg_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_req,
    input  logic             err_clear,
    input  logic             irq_mask,
    input  logic             wclk_rise,
    input  logic [LEN_W-1:0] data_len,
    input  logic [CNT_W-1:0] bclk_count,
    output logic             cnt_clear,
    output logic             cnt_active,
    output logic             run_grant,
    output logic             len_err,
    output logic             irq_out
);
    localparam int CMP_W = ((LEN_W + 1) > CNT_W) ? (LEN_W + 1) : CNT_W;

    flg_state_e state_q, state_d;
    logic [CMP_W-1:0] need_w;
    logic [CMP_W-1:0] have_w;
    logic             fits;

    assign need_w = CMP_W'({data_len, 1'b0});
    assign have_w = CMP_W'(bclk_count);
    assign fits   = (need_w <= have_w);

    always_comb begin
        state_d = state_q;
        if (!enable_req) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_ALIGN;
                ST_ALIGN:   if (wclk_rise) state_d = ST_MEASURE;
                ST_MEASURE: if (wclk_rise) state_d = fits ? ST_RUN : ST_FAULT;
                ST_RUN:     state_d = ST_RUN;
                ST_FAULT:   if (err_clear) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_clear  = 1'b0;
        cnt_active = 1'b0;
        run_grant  = 1'b0;
        len_err    = 1'b0;
        irq_out    = 1'b0;
        unique case (state_q)
            ST_IDLE:    cnt_clear = 1'b1;
            ST_ALIGN:   cnt_clear = 1'b1;
            ST_MEASURE: cnt_active = 1'b1;
            ST_RUN:     run_grant = 1'b1;
            ST_FAULT: begin
                len_err = 1'b1;
                irq_out = ~irq_mask;
            end
            default:    cnt_clear = 1'b1;
        endcase
    end
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard #(
    parameter int LEN_W       = 6,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             wclk_in,
    input  logic [LEN_W-1:0] data_len,
    input  logic             enable_req,
    input  logic             irq_mask,
    input  logic             err_clear,
    output logic             run_grant,
    output logic             len_err,
    output logic             irq_out
);
    localparam int N_CLK = 2;

    logic [N_CLK-1:0] raw_clks;
    logic [N_CLK-1:0] rises;
    logic [CNT_W-1:0] bclk_count;
    logic             cnt_clear;
    logic             cnt_active;

    assign raw_clks = {wclk_in, bclk_in};

    for (genvar g = 0; g < N_CLK; g++) begin : g_sync
        flg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (raw_clks[g]),
            .rise_o (rises[g])
        );
    end

    flg_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_active & rises[0]),
        .count (bclk_count)
    );

    flg_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_req (enable_req),
        .err_clear  (err_clear),
        .irq_mask   (irq_mask),
        .wclk_rise  (rises[1]),
        .data_len   (data_len),
        .bclk_count (bclk_count),
        .cnt_clear  (cnt_clear),
        .cnt_active (cnt_active),
        .run_grant  (run_grant),
        .len_err    (len_err),
        .irq_out    (irq_out)
    );
endmodule

// File: rtl/frame_len_guard_checker.sv
module frame_len_guard_checker (
    input logic clk,
    input logic rst_n,
    input logic enable_req,
    input logic irq_mask,
    input logic err_clear,
    input logic run_grant,
    input logic len_err,
    input logic irq_out
);
    assert_run_err_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_grant && len_err));

    assert_irq_follows_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (len_err && !irq_mask));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && enable_req && !err_clear) |=> len_err);

    assert_drop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_req |=> (!run_grant && !len_err && !irq_out));

    assert_grant_needs_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_grant) |-> $past(enable_req));
endmodule

bind frame_len_guard frame_len_guard_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_req (enable_req),
    .irq_mask   (irq_mask),
    .err_clear  (err_clear),
    .run_grant  (run_grant),
    .len_err    (len_err),
    .irq_out    (irq_out)
);

// File: tb/test_frame_len_guard.sv
module test_frame_len_guard;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bclk_in = 1'b0;
    logic             wclk_in = 1'b0;
    logic [LEN_W-1:0] data_len = '0;
    logic             enable_req = 1'b0;
    logic             irq_mask = 1'b0;
    logic             err_clear = 1'b0;
    logic             run_grant, len_err, irq_out;

    int vectors = 0;
    int fails   = 0;
    int frame_n = 8;
    bit done    = 1'b0;

    frame_len_guard #(.LEN_W(LEN_W), .CNT_W(8), .SYNC_STAGES(2)) i_frame_len_guard (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .wclk_in(wclk_in),
        .data_len(data_len), .enable_req(enable_req), .irq_mask(irq_mask),
        .err_clear(err_clear), .run_grant(run_grant), .len_err(len_err),
        .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    // Frame generator: six system clocks per bit clock, word clock
    // changes on the falling bit-clock edge, high for the first half.
    initial begin
        forever begin
            int n;
            n = frame_n;
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                bclk_in = 1'b0;
                wclk_in = (i < n / 2);
                repeat (3) @(negedge clk);
                bclk_in = 1'b1;
                repeat (2) @(negedge clk);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b (frame %0d, len %0d, mask %b)",
                     req, what, act, exp, frame_n, data_len, irq_mask);
        end
    endtask

    task automatic run_case(input int n, input int len, input logic mask);
        logic pass;
        enable_req = 1'b0;
        frame_n = n;
        @(posedge wclk_in);
        @(posedge wclk_in);
        repeat (20) @(negedge clk);
        data_len   = LEN_W'(len);
        irq_mask   = mask;
        enable_req = 1'b1;
        pass = (2 * len <= n);
        repeat (4) @(negedge clk);
        chk("R8", run_grant, 1'b0, "run_grant before frame closes");
        @(posedge wclk_in);
        @(posedge wclk_in);
        repeat (10) @(negedge clk);
        if (pass) begin
            chk("R3", run_grant, 1'b1, "run_grant on fitting length");
            chk("R3", len_err, 1'b0, "len_err on fitting length");
        end else begin
            chk("R4", run_grant, 1'b0, "run_grant on oversize length");
            chk("R4", len_err, 1'b1, "len_err on oversize length");
            chk("R5", irq_out, ~mask, "irq_out against mask");
            irq_mask = ~mask;
            @(negedge clk);
            chk("R5", irq_out, mask, "irq_out after mask flip");
            chk("R5", len_err, 1'b1, "len_err after mask flip");
            irq_mask = mask;
            @(posedge wclk_in);
            @(posedge wclk_in);
            repeat (4) @(negedge clk);
            chk("R6", len_err, 1'b1, "len_err held over frames");
            err_clear = 1'b1;
            @(negedge clk);
            err_clear = 1'b0;
            chk("R6", len_err, 1'b0, "len_err after clear");
            @(posedge wclk_in);
            @(posedge wclk_in);
            repeat (10) @(negedge clk);
            chk("R6", len_err, 1'b1, "len_err after re-measure");
        end
        enable_req = 1'b0;
        @(negedge clk);
        chk("R7", run_grant, 1'b0, "run_grant after request dropped");
        chk("R7", len_err, 1'b0, "len_err after request dropped");
        chk("R7", irq_out, 1'b0, "irq_out after request dropped");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1", run_grant, 1'b0, "run_grant in reset");
        chk("R1", len_err, 1'b0, "len_err in reset");
        chk("R1", irq_out, 1'b0, "irq_out in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", run_grant, 1'b0, "run_grant after reset");

        // R3 / R4 boundary at 40 bit clocks per frame
        run_case(40, 20, 1'b0);
        run_case(40, 21, 1'b0);
        run_case(40, 21, 1'b1);
        // R2: an odd frame and a zero length
        run_case(9, 4, 1'b0);
        run_case(9, 5, 1'b1);
        run_case(12, 0, 1'b0);

        for (int n = 4; n <= 40; n += 2) begin
            run_case(n, n / 2 - 1, 1'b0);
            run_case(n, n / 2, 1'b0);
            run_case(n, n / 2 + 1, n[1]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule